// File: doc/BRIEF.md
# Fixed-Length Instruction Decoder

This block turns one 16-bit instruction word per clock into the control bundle that drives an 8-bit processor's register file and execution units. The upper byte always holds a 4-bit opcode, a 3-bit target register index and a conditional-execution bit. The lower byte has two meanings, chosen by the opcode. In register forms it carries a condition-invert bit, an extra-segment select, a second register index and a 3-bit field. That 3-bit field is either a third register index or a sub-operation code. In immediate forms the whole lower byte is an 8-bit literal.

Every output is registered, so the bundle for a word presented with `valid_i` appears one clock later. The decoder resolves which register indices feed read ports A and B. For add and subtract, port A takes the second register and port B takes the third. For the two-register bitwise group, the target is reused as the second source. Opcodes 10 to 15 are reported as illegal and write nothing. Register index 6 is the stack pointer and index 7 is the instruction pointer. Index 7 turns a push-and-move into a call.

Top module: `instr_decoder`

## Requirements
- R1: Outputs are registered. The bundle for a word sampled with `valid_i`=1 appears on the outputs after the next rising edge, with `valid_o`=1. After a clock where `valid_i`=0, `valid_o` and every other output are 0.
- R2: For opcodes 0 to 9: `opcode_o`=instr[15:12], `tgt_o`=instr[11:9] and `cond_en_o`=instr[8].
- R3: In register forms (legal opcodes other than 1 and 4), `cond_inv_o`=instr[7] and `use_es_o`=instr[6]. The second register index is instr[5:3] and the third field is instr[2:0].
- R4: In immediate forms (opcode 1 move-immediate, opcode 4 push-immediate), `imm_sel_o`=1, `imm_o`=instr[7:0] and `cond_inv_o`=`use_es_o`=0. For every other opcode, `imm_sel_o`=0 and `imm_o`=0.
- R5: Add (7) and subtract (8) set `wr_en_o`, `rd_a_en_o` and `rd_b_en_o`, with `src_a_o`=instr[5:3] and `src_b_o`=instr[2:0].
- R6: Bitwise (9) sets `wr_en_o` and `rd_a_en_o`, with `src_a_o`=instr[5:3] and `subop_o`=instr[2:0]. The sub-op codes are 0 and, 1 or, 2 xor, 3 not, 4 shift left, 5 shift right, 6 rotate right, 7 rotate left. Port B reads the target (`src_b_o`=`tgt_o`, `rd_b_en_o`=1) except for not (3), where `rd_b_en_o`=0.
- R7: Compare (6) reads the target on port A and instr[5:3] on port B, with `subop_o`=instr[2:0]. It does not write a register.
- R8: Move (2) and push-and-move (5) write the target and read instr[5:3] on port A. `call_o`=1 only for opcode 5 with target 7.
- R9: Push (3) reads the target on port A and writes nothing. Move-immediate (1) writes the target and reads nothing. Push-immediate (4) and no-op (0) neither read nor write.
- R10: Opcodes 10 to 15 give `illegal_o`=1 and `opcode_o`=instr[15:12]. Every enable, index, sub-op, immediate, condition and call output is 0.
- R11: While `rst_n`=0, all outputs are 0.
- R12: `src_a_o` is 0 whenever `rd_a_en_o`=0, and `src_b_o` is 0 whenever `rd_b_en_o`=0. `subop_o` is 0 for opcodes other than 6 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 16 | Instruction word |
| valid_o | output | 1 | Decoded bundle valid |
| opcode_o | output | 4 | Opcode class |
| illegal_o | output | 1 | Unassigned opcode |
| tgt_o | output | 3 | Target register index |
| src_a_o | output | 3 | Read port A register index |
| src_b_o | output | 3 | Read port B register index |
| rd_a_en_o | output | 1 | Read port A used |
| rd_b_en_o | output | 1 | Read port B used |
| wr_en_o | output | 1 | Target register written |
| subop_o | output | 3 | Compare/bitwise sub-operation |
| imm_o | output | 8 | Immediate literal |
| imm_sel_o | output | 1 | Immediate form |
| cond_en_o | output | 1 | Conditional execution requested |
| cond_inv_o | output | 1 | Execute only when condition is false |
| use_es_o | output | 1 | Extra segment selected |
| call_o | output | 1 | Push-and-move to instruction pointer |

## Verification
The in-RTL assertions check, on every cycle, the cross-output rules. An illegal word never writes. An immediate form never carries segment or invert flags and never reads a register. A call always targets index 7. A bitwise port-B read always names the target. Idle cycles are silent, and an accepted word yields a valid bundle one clock later. Whether each field is taken from the right bit positions, and whether every opcode gets the right read/write pattern, only the bench can show. It sweeps all 65536 instruction words back-to-back, with idle slots interleaved, and compares every output against values computed from the encoding.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int REG_W   = 3;
    localparam int IMM_W   = INSTR_W / 2;
    localparam int SUB_W   = 3;

    localparam logic [OPC_W-1:0] OPC_NOP   = 4'd0;
    localparam logic [OPC_W-1:0] OPC_MOVI  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_MOV   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_PUSH  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_PUSHI = 4'd4;
    localparam logic [OPC_W-1:0] OPC_PMOV  = 4'd5;
    localparam logic [OPC_W-1:0] OPC_CMP   = 4'd6;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd7;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'd8;
    localparam logic [OPC_W-1:0] OPC_BIT   = 4'd9;
    localparam logic [OPC_W-1:0] OPC_LAST  = OPC_BIT;

    localparam logic [SUB_W-1:0] BOP_NOT   = 3'd3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TGT  = 2'd1,
        SEL_OTH  = 2'd2,
        SEL_THR  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic [OPC_W-1:0] op;
        logic [REG_W-1:0] tgt;
        logic             cond;
        logic             inv;
        logic             es;
        logic [REG_W-1:0] oth;
        logic [REG_W-1:0] thr;
        logic [IMM_W-1:0] imm;
    } idec_fields_t;

    typedef struct packed {
        logic     legal;
        logic     imm_form;
        logic     wr;
        src_sel_e a_sel;
        src_sel_e b_sel;
        logic     has_sub;
    } idec_ctl_t;

    typedef struct packed {
        logic             valid;
        logic [OPC_W-1:0] opcode;
        logic             illegal;
        logic [REG_W-1:0] tgt;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic             rd_a_en;
        logic             rd_b_en;
        logic             wr_en;
        logic [SUB_W-1:0] subop;
        logic [IMM_W-1:0] imm;
        logic             imm_sel;
        logic             cond_en;
        logic             cond_inv;
        logic             use_es;
        logic             call;
    } idec_out_t;

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output idec_fields_t       fields
);

    localparam int HI_LSB  = IMM_W;
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int TGT_LSB = OPC_LSB - REG_W;
    localparam int CND_BIT = TGT_LSB - 1;

    always_comb begin
        fields.op   = instr[OPC_LSB +: OPC_W];
        fields.tgt  = instr[TGT_LSB +: REG_W];
        fields.cond = instr[CND_BIT];
        fields.inv  = instr[HI_LSB - 1];
        fields.es   = instr[HI_LSB - 2];
        fields.oth  = instr[REG_W +: REG_W];
        fields.thr  = instr[0 +: REG_W];
        fields.imm  = instr[0 +: IMM_W];
    end

endmodule

// File: rtl/idec_ctl.sv
module idec_ctl
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    input  logic [REG_W-1:0] thr,
    output idec_ctl_t        ctl
);

    always_comb begin
        ctl       = '0;
        ctl.a_sel = SEL_NONE;
        ctl.b_sel = SEL_NONE;
        ctl.legal = (op <= OPC_LAST);
        unique case (op)
            OPC_NOP: begin
            end
            OPC_MOVI: begin
                ctl.imm_form = 1'b1;
                ctl.wr       = 1'b1;
            end
            OPC_MOV, OPC_PMOV: begin
                ctl.wr    = 1'b1;
                ctl.a_sel = SEL_OTH;
            end
            OPC_PUSH: begin
                ctl.a_sel = SEL_TGT;
            end
            OPC_PUSHI: begin
                ctl.imm_form = 1'b1;
            end
            OPC_CMP: begin
                ctl.a_sel   = SEL_TGT;
                ctl.b_sel   = SEL_OTH;
                ctl.has_sub = 1'b1;
            end
            OPC_ADD, OPC_SUB: begin
                ctl.wr    = 1'b1;
                ctl.a_sel = SEL_OTH;
                ctl.b_sel = SEL_THR;
            end
            OPC_BIT: begin
                ctl.wr      = 1'b1;
                ctl.a_sel   = SEL_OTH;
                ctl.b_sel   = (thr == BOP_NOT) ? SEL_NONE : SEL_TGT;
                ctl.has_sub = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import idec_pkg::*;
#(
    parameter int IP_IDX = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               valid_o,
    output logic [OPC_W-1:0]   opcode_o,
    output logic               illegal_o,
    output logic [REG_W-1:0]   tgt_o,
    output logic [REG_W-1:0]   src_a_o,
    output logic [REG_W-1:0]   src_b_o,
    output logic               rd_a_en_o,
    output logic               rd_b_en_o,
    output logic               wr_en_o,
    output logic [SUB_W-1:0]   subop_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic               imm_sel_o,
    output logic               cond_en_o,
    output logic               cond_inv_o,
    output logic               use_es_o,
    output logic               call_o
);

    localparam logic [REG_W-1:0] IP_REG = REG_W'(IP_IDX);

    idec_fields_t fld;
    idec_ctl_t    ctl;
    idec_out_t    dec_d, dec_q;

    idec_fields u_fields (
        .instr  (instr_i),
        .fields (fld)
    );

    idec_ctl u_ctl (
        .op  (fld.op),
        .thr (fld.thr),
        .ctl (ctl)
    );

    function automatic logic [REG_W-1:0] pick(input src_sel_e s, input idec_fields_t f);
        unique case (s)
            SEL_TGT: pick = f.tgt;
            SEL_OTH: pick = f.oth;
            SEL_THR: pick = f.thr;
            default: pick = '0;
        endcase
    endfunction

    always_comb begin
        dec_d = '0;
        if (valid_i) begin
            dec_d.valid   = 1'b1;
            dec_d.opcode  = fld.op;
            dec_d.illegal = !ctl.legal;
            if (ctl.legal) begin
                dec_d.tgt      = fld.tgt;
                dec_d.cond_en  = fld.cond;
                dec_d.wr_en    = ctl.wr;
                dec_d.rd_a_en  = (ctl.a_sel != SEL_NONE);
                dec_d.rd_b_en  = (ctl.b_sel != SEL_NONE);
                dec_d.src_a    = pick(ctl.a_sel, fld);
                dec_d.src_b    = pick(ctl.b_sel, fld);
                dec_d.subop    = ctl.has_sub ? fld.thr : '0;
                dec_d.imm_sel  = ctl.imm_form;
                dec_d.imm      = ctl.imm_form ? fld.imm : '0;
                dec_d.cond_inv = ctl.imm_form ? 1'b0 : fld.inv;
                dec_d.use_es   = ctl.imm_form ? 1'b0 : fld.es;
                dec_d.call     = (fld.op == OPC_PMOV) && (fld.tgt == IP_REG);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign valid_o    = dec_q.valid;
    assign opcode_o   = dec_q.opcode;
    assign illegal_o  = dec_q.illegal;
    assign tgt_o      = dec_q.tgt;
    assign src_a_o    = dec_q.src_a;
    assign src_b_o    = dec_q.src_b;
    assign rd_a_en_o  = dec_q.rd_a_en;
    assign rd_b_en_o  = dec_q.rd_b_en;
    assign wr_en_o    = dec_q.wr_en;
    assign subop_o    = dec_q.subop;
    assign imm_o      = dec_q.imm;
    assign imm_sel_o  = dec_q.imm_sel;
    assign cond_en_o  = dec_q.cond_en;
    assign cond_inv_o = dec_q.cond_inv;
    assign use_es_o   = dec_q.use_es;
    assign call_o     = dec_q.call;

    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R1

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!illegal_o && !wr_en_o && !rd_a_en_o && !rd_b_en_o && !imm_sel_o && opcode_o == '0)); // R1

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !rd_a_en_o && !rd_b_en_o && !call_o && !cond_en_o)); // R10

    AST_ILLEGAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (opcode_o > OPC_LAST)); // R10

    AST_IMM_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sel_o |-> (!cond_inv_o && !use_es_o && !rd_a_en_o && !rd_b_en_o)); // R4

    AST_CALL_TO_IP: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> (tgt_o == IP_REG && opcode_o == OPC_PMOV && wr_en_o)); // R8

    AST_BIT_TARGET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && opcode_o == OPC_BIT && rd_b_en_o) |-> (src_b_o == tgt_o)); // R6

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && opcode_o == OPC_CMP) |-> !wr_en_o); // R7

    AST_UNUSED_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_a_en_o |-> src_a_o == '0) and (!rd_b_en_o |-> src_b_o == '0)); // R12

endmodule

// File: tb/instr_decoder_tb.sv
`timescale 1ns/1ps
module instr_decoder_tb;
    import idec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    idec_out_t   act;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    instr_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .instr_i    (instr_i),
        .valid_o    (act.valid),
        .opcode_o   (act.opcode),
        .illegal_o  (act.illegal),
        .tgt_o      (act.tgt),
        .src_a_o    (act.src_a),
        .src_b_o    (act.src_b),
        .rd_a_en_o  (act.rd_a_en),
        .rd_b_en_o  (act.rd_b_en),
        .wr_en_o    (act.wr_en),
        .subop_o    (act.subop),
        .imm_o      (act.imm),
        .imm_sel_o  (act.imm_sel),
        .cond_en_o  (act.cond_en),
        .cond_inv_o (act.cond_inv),
        .use_es_o   (act.use_es),
        .call_o     (act.call)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] a, input logic [7:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, a, e);
        end
    endtask

    // Expected bundle, written from the requirement text.
    function automatic idec_out_t model(input bit v, input logic [15:0] w);
        idec_out_t e;
        logic [3:0] op;
        logic [2:0] t, o, x;
        e  = '0;
        op = w[15:12];
        t  = w[11:9];
        o  = w[5:3];
        x  = w[2:0];
        if (!v) return e;                    // R1 idle slot
        e.valid  = 1'b1;
        e.opcode = op;
        if (op >= 4'd10) begin               // R10
            e.illegal = 1'b1;
            return e;
        end
        e.tgt     = t;                       // R2
        e.cond_en = w[8];
        if (op == 4'd1 || op == 4'd4) begin  // R4
            e.imm_sel = 1'b1;
            e.imm     = w[7:0];
        end else begin                       // R3
            e.cond_inv = w[7];
            e.use_es   = w[6];
        end
        case (op)
            4'd1: e.wr_en = 1'b1;                                        // R9
            4'd3: begin e.rd_a_en = 1'b1; e.src_a = t; end               // R9
            4'd2, 4'd5: begin                                            // R8
                e.wr_en = 1'b1; e.rd_a_en = 1'b1; e.src_a = o;
                e.call  = (op == 4'd5) && (t == 3'd7);
            end
            4'd6: begin                                                  // R7
                e.rd_a_en = 1'b1; e.src_a = t;
                e.rd_b_en = 1'b1; e.src_b = o; e.subop = x;
            end
            4'd7, 4'd8: begin                                            // R5
                e.wr_en = 1'b1;
                e.rd_a_en = 1'b1; e.src_a = o;
                e.rd_b_en = 1'b1; e.src_b = x;
            end
            4'd9: begin                                                  // R6
                e.wr_en = 1'b1; e.rd_a_en = 1'b1; e.src_a = o; e.subop = x;
                if (x != 3'd3) begin e.rd_b_en = 1'b1; e.src_b = t; end
            end
            default: ;
        endcase
        return e;
    endfunction

    function automatic string cls_tag(input bit v, input logic [3:0] op);
        if (!v) return "R1";
        case (op)
            4'd7, 4'd8: return "R5";
            4'd9:       return "R6";
            4'd6:       return "R7";
            4'd2, 4'd5: return "R8";
            4'd0, 4'd1, 4'd3, 4'd4: return "R9";
            default:    return "R10";
        endcase
    endfunction

    task automatic compare(input bit v, input logic [15:0] w);
        idec_out_t e;
        string     ct;
        e  = model(v, w);
        ct = v ? "R2" : "R1";
        chk(v ? "R1" : "R1", "valid", 8'(act.valid), 8'(e.valid));
        if (v && w[15:12] >= 4'd10) ct = "R10";
        chk(ct, "opcode", 8'(act.opcode), 8'(e.opcode));
        chk(ct, "tgt", 8'(act.tgt), 8'(e.tgt));
        chk(ct, "cond_en", 8'(act.cond_en), 8'(e.cond_en));
        chk(v ? "R3" : "R1", "cond_inv", 8'(act.cond_inv), 8'(e.cond_inv));
        chk(v ? "R3" : "R1", "use_es", 8'(act.use_es), 8'(e.use_es));
        chk(v ? "R4" : "R1", "imm", act.imm, e.imm);
        chk(v ? "R4" : "R1", "imm_sel", 8'(act.imm_sel), 8'(e.imm_sel));
        ct = cls_tag(v, w[15:12]);
        chk(ct, "illegal", 8'(act.illegal), 8'(e.illegal));
        chk(ct, "wr_en", 8'(act.wr_en), 8'(e.wr_en));
        chk(ct, "rd_a_en", 8'(act.rd_a_en), 8'(e.rd_a_en));
        chk(ct, "rd_b_en", 8'(act.rd_b_en), 8'(e.rd_b_en));
        chk(ct, "src_a", 8'(act.src_a), 8'(e.src_a));
        chk(ct, "src_b", 8'(act.src_b), 8'(e.src_b));
        chk(ct, "subop", 8'(act.subop), 8'(e.subop));
        chk(ct, "call", 8'(act.call), 8'(e.call));
        // R12: unused read indices and sub-op read as zero
        if (!e.rd_a_en) chk("R12", "src_a idle", 8'(act.src_a), 8'h00);
        if (!e.rd_b_en) chk("R12", "src_b idle", 8'(act.src_b), 8'h00);
        if (w[15:12] != 4'd6 && w[15:12] != 4'd9)
            chk("R12", "subop idle", 8'(act.subop), 8'h00);
    endtask

    bit          have_prev = 1'b0;
    bit          prev_v;
    logic [15:0] prev_w;

    task automatic step(input bit v, input logic [15:0] w);
        @(negedge clk);
        if (have_prev) compare(prev_v, prev_w);
        valid_i   = v;
        instr_i   = w;
        prev_v    = v;
        prev_w    = w;
        have_prev = 1'b1;
    endtask

    initial begin
        valid_i = 1'b1;
        instr_i = 16'h5E3F;
        repeat (3) @(negedge clk);
        // R11: reset holds every output at zero
        chk("R11", "bundle in reset", 8'(act != '0), 8'h00);
        chk("R11", "valid in reset", 8'(act.valid), 8'h00);
        rst_n   = 1'b1;
        valid_i = 1'b0;
        for (int i = 0; i < 65536; i++) begin
            if (i[3:0] == 4'd0) step(1'b0, ~16'(i));
            step(1'b1, 16'(i));
        end
        step(1'b0, 16'hFFFF);
        @(negedge clk);
        compare(prev_v, prev_w);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule